// File: doc/BRIEF.md
# Relocating Accumulator Processor

This block is a small single-accumulator processor in which every memory reference is virtual. Before any address reaches the memory port it is compared against a limit value and then offset by a relocation (base) value. Instruction fetches and operand reads and writes are all mapped this way. Branch targets are kept in virtual form, so a program runs unchanged wherever the base places it. If a check fails, or the opcode is undefined, the access is suppressed and the core stops in a fault state until reset.

A supervisor prepares a process by writing the base and limit through a dedicated load port while the core is idle, then pulses `start`. Memory has one synchronous port with one cycle of read latency. A controller therefore steps through named states:

- `ST_IDLE` (halted, mapping loadable) goes to `ST_FETCH` on `start`.
- `ST_FETCH` checks the program counter and issues the read. It goes to `ST_DECODE` if the address is in range and to `ST_FAULT` if not.
- `ST_DECODE` splits the returned word, advances or reloads the program counter and issues the operand access. An add goes on to `ST_OPERAND`. A store or a branch goes back to `ST_FETCH`. A range failure or an undefined opcode goes to `ST_FAULT`.
- `ST_OPERAND` accumulates the returned word and goes to `ST_FETCH`.
- `ST_FAULT` is left only by reset.

Top module: `reloc_acc_cpu`

## Requirements
- R1: After reset the core is halted in idle, with `halted`=1, `fault`=0, `fault_cause`=0, `pc_out`=0, `acc_out`=0, and no memory read or write. Both the base and the limit are cleared to 0.
- R2: A pulse on `map_we` loads `map_base` and `map_limit` only while the core is idle. In any other state the pulse is ignored.
- R3: A fetch reads physical address base+PC (modulo 2^16) when PC < limit. The instruction word holds the opcode in bits 15:12 and a 12-bit address in bits 11:0. The program counter then advances by one (modulo 2^12) unless the instruction is a branch.
- R4: Opcode 1 reads physical address base+address and adds the returned word into the accumulator, modulo 2^16.
- R5: Opcode 2 writes the accumulator to physical address base+address with `mem_we`=1.
- R6: Opcode 3 loads the untranslated 12-bit address into the program counter. The next fetch then goes to base+address. A branch makes no data access and no range check.
- R7: A fetch or operand address that is equal to or above the limit performs no access. It enters the fault state with `fault_cause`=2'b01.
- R8: Opcodes 0 and 4–15 perform no access and enter the fault state with `fault_cause`=2'b10.
- R9: In the fault state `fault`=1 and `halted`=1, and no memory access is made. `start` and `map_we` have no effect there, and only reset leaves it.
- R10: An add takes three cycles (fetch, decode, operand). A store or a branch takes two. Execution begins in the cycle after `start` is sampled in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution from idle |
| map_we | input | 1 | Load base and limit (idle only) |
| map_base | input | 16 | Relocation value to load |
| map_limit | input | 16 | Limit value to load |
| mem_addr | output | 16 | Physical memory address |
| mem_rd | output | 1 | Read request; data appears one cycle later |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Read data |
| halted | output | 1 | Core idle or faulted |
| fault | output | 1 | Core stopped by an exception |
| fault_cause | output | 2 | 01 range, 10 undefined opcode, 00 none |
| pc_out | output | 12 | Virtual program counter |
| acc_out | output | 16 | Accumulator |

## Verification
A corrupted state register, base or limit shows on `mem_addr`, `mem_rd` or `mem_we` in the very next access cycle, so a cycle-exact reference model catches it within one clock. A wrong program counter or accumulator is visible at once on `pc_out`/`acc_out`, and it reaches memory at the next fetch or store. Faults are exercised at the limit boundary for both fetch and operand, with undefined opcodes both at the low end and inside the range. The run also covers mapping writes attempted while running and while faulted.

// File: rtl/reloc_acc_pkg.sv
package reloc_acc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_OPERAND,
        ST_FAULT
    } cpu_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_RANGE  = 2'b01,
        CAUSE_OPCODE = 2'b10
    } fault_cause_t;

    localparam int OP_ADD   = 1;
    localparam int OP_STORE = 2;
    localparam int OP_JUMP  = 3;
endpackage

// File: rtl/reloc_map_regs.sv
module reloc_map_regs #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] limit_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] limit_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (load) begin
            base_q  <= base_in;
            limit_q <= limit_in;
        end
    end

    // R2: mapping only changes through an accepted load
    p_map_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(base_q) && $stable(limit_q)));
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
    parameter int VADDR_W = 12,
    parameter int PADDR_W = 16
) (
    input  logic [VADDR_W-1:0] vaddr,
    input  logic [PADDR_W-1:0] base,
    input  logic [PADDR_W-1:0] limit,
    output logic [PADDR_W-1:0] paddr,
    output logic               in_range
);
    logic [PADDR_W-1:0] vwide;

    always_comb begin
        vwide    = PADDR_W'(vaddr);
        in_range = (vwide < limit);
        paddr    = base + vwide;
    end
endmodule

// File: rtl/reloc_acc_cpu.sv
module reloc_acc_cpu
    import reloc_acc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int OP_W    = 4,
    parameter int PADDR_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          map_we,
    input  logic [PADDR_W-1:0]            map_base,
    input  logic [PADDR_W-1:0]            map_limit,
    output logic [PADDR_W-1:0]            mem_addr,
    output logic                          mem_rd,
    output logic                          mem_we,
    output logic [DATA_W-1:0]             mem_wdata,
    input  logic [DATA_W-1:0]             mem_rdata,
    output logic                          halted,
    output logic                          fault,
    output logic [1:0]                    fault_cause,
    output logic [DATA_W-OP_W-1:0]        pc_out,
    output logic [DATA_W-1:0]             acc_out
);
    localparam int VADDR_W = DATA_W - OP_W;

    cpu_state_t         state_q, state_d;
    fault_cause_t       cause_q, cause_d;
    logic [VADDR_W-1:0] pc_q;
    logic [DATA_W-1:0]  acc_q;
    logic [OP_W-1:0]    op;
    logic [VADDR_W-1:0] adr;
    logic [VADDR_W-1:0] vaddr;
    logic [PADDR_W-1:0] base_q, limit_q, paddr;
    logic               in_range;
    logic               map_load;

    assign op       = mem_rdata[DATA_W-1 -: OP_W];
    assign adr      = mem_rdata[VADDR_W-1:0];
    assign vaddr    = (state_q == ST_FETCH) ? pc_q : adr;
    assign map_load = map_we && (state_q == ST_IDLE);

    reloc_map_regs #(.ADDR_W(PADDR_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (map_load),
        .base_in  (map_base),
        .limit_in (map_limit),
        .base_q   (base_q),
        .limit_q  (limit_q)
    );

    reloc_xlate #(.VADDR_W(VADDR_W), .PADDR_W(PADDR_W)) u_xlate (
        .vaddr    (vaddr),
        .base     (base_q),
        .limit    (limit_q),
        .paddr    (paddr),
        .in_range (in_range)
    );

    // state register and architectural registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= CAUSE_NONE;
            pc_q    <= '0;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            if (state_q == ST_DECODE) begin
                if (int'(op) == OP_JUMP) pc_q <= adr;
                else                     pc_q <= pc_q + VADDR_W'(1);
            end
            if (state_q == ST_OPERAND) acc_q <= acc_q + mem_rdata;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cause_d   = cause_q;
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (in_range) begin
                    mem_rd   = 1'b1;
                    mem_addr = paddr;
                    state_d  = ST_DECODE;
                end else begin
                    state_d = ST_FAULT;
                    cause_d = CAUSE_RANGE;
                end
            end
            ST_DECODE: begin
                if (int'(op) == OP_JUMP) begin
                    state_d = ST_FETCH;
                end else if (int'(op) == OP_ADD || int'(op) == OP_STORE) begin
                    if (!in_range) begin
                        state_d = ST_FAULT;
                        cause_d = CAUSE_RANGE;
                    end else if (int'(op) == OP_ADD) begin
                        mem_rd   = 1'b1;
                        mem_addr = paddr;
                        state_d  = ST_OPERAND;
                    end else begin
                        mem_we    = 1'b1;
                        mem_addr  = paddr;
                        mem_wdata = acc_q;
                        state_d   = ST_FETCH;
                    end
                end else begin
                    state_d = ST_FAULT;
                    cause_d = CAUSE_OPCODE;
                end
            end
            ST_OPERAND: begin
                state_d = ST_FETCH;
            end
            ST_FAULT: begin
                state_d = ST_FAULT;
            end
            default: begin
                state_d = ST_FAULT;
                cause_d = CAUSE_OPCODE;
            end
        endcase
    end

    assign halted      = (state_q == ST_IDLE) || (state_q == ST_FAULT);
    assign fault       = (state_q == ST_FAULT);
    assign fault_cause = cause_q;
    assign pc_out      = pc_q;
    assign acc_out     = acc_q;

    // R9: faults are sticky and silent
    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
    p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_rd && !mem_we));
    // R7: a fetch without a read request must end in a range fault
    p_fetch_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && !mem_rd) |=> (fault && fault_cause == 2'b01));
    // R3: non-branch decode steps the program counter by one
    p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && int'(op) != OP_JUMP) |=> (pc_q == $past(pc_q) + VADDR_W'(1)));
    // R6: a branch keeps the virtual target
    p_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && int'(op) == OP_JUMP) |=> (pc_q == $past(adr)));
    // R5: at most one kind of access per cycle
    p_one_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we));
    // R4: accumulator changes only after an operand read
    p_acc_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OPERAND) |=> $stable(acc_q));
endmodule

// File: tb/reloc_acc_cpu_test.sv
module reloc_acc_cpu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        map_we = 1'b0;
    logic [15:0] map_base = '0, map_limit = '0;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_rd, mem_we;
    logic [15:0] rdata = '0;
    logic        halted, fault;
    logic [1:0]  fault_cause;
    logic [11:0] pc_out;
    logic [15:0] acc_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [15:0] mem [logic [15:0]];

    // reference model state: 0 idle,1 fetch,2 decode,3 operand,4 fault
    int ms = 0, mpc = 0, macc = 0, mbase = 0, mlimit = 0, mcause = 0;

    always #4 clk = ~clk;   // 125 MHz

    reloc_acc_cpu uut (
        .clk(clk), .rst_n(rst_n), .start(start), .map_we(map_we),
        .map_base(map_base), .map_limit(map_limit),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(rdata),
        .halted(halted), .fault(fault), .fault_cause(fault_cause),
        .pc_out(pc_out), .acc_out(acc_out)
    );

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // memory: one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] = mem_wdata;
        if (mem_rd) rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 16'h0;
    end

    // behavioural reference model
    always @(posedge clk) begin
        int op, a;
        cycles++;
        op = int'(rdata[15:12]);
        a  = int'(rdata[11:0]);
        if (!rst_n) begin
            ms = 0; mpc = 0; macc = 0; mbase = 0; mlimit = 0; mcause = 0;
        end else begin
            case (ms)
                0: begin
                    if (map_we) begin mbase = map_base; mlimit = map_limit; end
                    if (start) ms = 1;
                end
                1: if (mpc < mlimit) ms = 2; else begin ms = 4; mcause = 1; end
                2: begin
                    if (op == 3) begin mpc = a; ms = 1; end
                    else begin
                        mpc = (mpc + 1) & 12'hfff;
                        if (op == 1 || op == 2) begin
                            if (a < mlimit) ms = (op == 1) ? 3 : 1;
                            else begin ms = 4; mcause = 1; end
                        end else begin ms = 4; mcause = 2; end
                    end
                end
                3: begin macc = (macc + int'(rdata)) & 16'hffff; ms = 1; end
                default: ms = 4;
            endcase
        end
    end

    // per-cycle comparison away from the edge
    always begin
        int e_rd, e_we, e_addr, e_wd, op, a;
        @(posedge clk);
        #6;
        if (rst_n) begin
            e_rd = 0; e_we = 0; e_addr = 0; e_wd = 0;
            op = int'(rdata[15:12]);
            a  = int'(rdata[11:0]);
            if (ms == 1 && mpc < mlimit) begin e_rd = 1; e_addr = (mbase + mpc) & 16'hffff; end
            if (ms == 2 && (op == 1 || op == 2) && a < mlimit) begin
                e_addr = (mbase + a) & 16'hffff;
                if (op == 1) e_rd = 1; else begin e_we = 1; e_wd = macc; end
            end
            chk("R3 mem_rd", int'(mem_rd), e_rd);
            chk("R3 mem_addr", int'(mem_addr), e_addr);
            chk("R5 mem_we", int'(mem_we), e_we);
            chk("R5 mem_wdata", int'(mem_wdata), e_wd);
            chk("R7 fault", int'(fault), (ms == 4) ? 1 : 0);
            chk("R8 fault_cause", int'(fault_cause), mcause);
            chk("R9 halted", int'(halted), (ms == 0 || ms == 4) ? 1 : 0);
            chk("R6 pc_out", int'(pc_out), mpc);
            chk("R4 acc_out", int'(acc_out), macc);
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        @(posedge clk);
        while (cycles < 50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        finish_run();
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; map_we = 1'b0;
        mem.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_map(int b, int l);
        map_we = 1'b1; map_base = 16'(b); map_limit = 16'(l);
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic go();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_fault();
        for (int i = 0; i < 200 && !fault; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 halted", int'(halted), 1);
        chk("R1 fault", int'(fault), 0);
        chk("R1 pc", int'(pc_out), 0);
        chk("R1 acc", int'(acc_out), 0);
        chk("R1 mem_rd", int'(mem_rd), 0);

        // main program: base 0x100, limit 0x20
        mem[16'h100] = 16'h1010; mem[16'h101] = 16'h1011;
        mem[16'h102] = 16'h2012; mem[16'h103] = 16'h3005;
        mem[16'h104] = 16'h0000; mem[16'h105] = 16'h2013;
        mem[16'h106] = 16'h101F; mem[16'h107] = 16'h1020;
        mem[16'h110] = 16'h0005; mem[16'h111] = 16'hFFFF;
        mem[16'h11F] = 16'h0003;
        load_map(16'h100, 16'h20);
        go();
        repeat (16) @(negedge clk);
        chk("R10 not yet faulted", int'(fault), 0);
        @(negedge clk);
        chk("R10 fault cycle", int'(fault), 1);
        chk("R4 acc sum with wrap", int'(acc_out), 7);
        chk("R5 stored word", int'(mem[16'h112]), 4);
        chk("R6 branch skipped word", int'(mem[16'h113]), 4);
        chk("R7 operand at limit cause", int'(fault_cause), 1);
        chk("R3 pc advanced", int'(pc_out), 8);
        // R9: start and map load ignored while faulted
        start = 1'b1; map_we = 1'b1; map_base = 16'h0; map_limit = 16'hFFFF;
        repeat (4) @(negedge clk);
        start = 1'b0; map_we = 1'b0;
        chk("R9 still faulted", int'(fault), 1);
        chk("R9 no read", int'(mem_rd), 0);

        // R8 opcode 4 after a branch
        do_reset();
        chk("R1 acc after reset", int'(acc_out), 0);
        mem[16'h200] = 16'h3003; mem[16'h203] = 16'h4000;
        load_map(16'h200, 16'h4);
        go();
        wait_fault();
        chk("R8 opcode 4 cause", int'(fault_cause), 2);
        chk("R8 pc after illegal", int'(pc_out), 4);

        // R8 opcode 0
        do_reset();
        mem[16'h250] = 16'h0123;
        load_map(16'h250, 16'h10);
        go();
        wait_fault();
        chk("R8 opcode 0 cause", int'(fault_cause), 2);

        // R7 fetch with zero limit after reset
        do_reset();
        go();
        chk("R7 fetch no read", int'(mem_rd), 0);
        @(negedge clk);
        chk("R7 fetch fault cause", int'(fault_cause), 1);

        // R2 map load while running is ignored
        do_reset();
        mem[16'h300] = 16'h3000;
        load_map(16'h300, 16'h10);
        go();
        repeat (3) @(negedge clk);
        map_we = 1'b1; map_base = 16'h0; map_limit = 16'h1;
        @(negedge clk);
        map_we = 1'b0;
        for (int i = 0; i < 4 && !mem_rd; i++) @(negedge clk);
        chk("R2 fetch base kept", int'(mem_addr), 16'h300);
        repeat (6) @(negedge clk);
        chk("R2 still running", int'(halted), 0);

        // R7 store at limit-1 succeeds, at limit faults with no write
        do_reset();
        mem[16'h400] = 16'h2002; mem[16'h401] = 16'h2003;
        load_map(16'h400, 16'h3);
        go();
        wait_fault();
        chk("R5 store below limit", int'(mem.exists(16'h402)), 1);
        chk("R7 store at limit suppressed", int'(mem.exists(16'h403)), 0);
        chk("R7 store fault cause", int'(fault_cause), 1);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule